// File: doc/BRIEF.md
# Transmit Entry-Slot Empty Flag

This block produces the status flag a host polls before it writes the next character into a serial transmitter. The flag watches only the entry slot of the transmit FIFO. When the flag is high, the slot is free and one more character can be written without overwriting anything. The block owns the entry slot itself: it accepts a host write only when the flag is high, presents the held character to the next FIFO stage, and frees the slot when that stage takes the character.

In the synchronous framing modes the transmit engine raises a CRC indication while it sends the frame check sequence. The flag is forced low for that whole time, even if the slot is free. In asynchronous mode that indication has no effect. A write that arrives while the flag is low is dropped and sets a sticky overrun bit. A hardware reset or a channel reset empties the slot, raises the flag and clears the overrun bit. The flag depends on nothing else, so transmit interrupt configuration cannot change it.

Top module: `tbe_status_tracker`

## Requirements
- R1: In the cycle after `rst` or `chan_rst` is high, `tx_empty` is 1, `overrun` is 0, `slot_valid` is 0 and `slot_data` is 0.
- R2: A `host_wr` while `tx_empty` is 1 loads `host_data` into the slot. In the next cycle `tx_empty` is 0, `slot_valid` is 1 and `slot_data` holds the written value.
- R3: A `slot_advance` while `slot_valid` is 1 frees the slot. In the next cycle `slot_valid` is 0, and `tx_empty` is 1 unless a CRC hold applies (R5).
- R4: A `slot_advance` while the slot is empty has no effect on `tx_empty`, `slot_valid`, `slot_data` or `overrun`.
- R5: When `frame_mode` is not 2'b00 (01 = character sync, 10 = bit-oriented framed, 11 = external sync) and `crc_active` is 1, `tx_empty` is 0 in the next cycle. It returns to 1 the cycle after `crc_active` falls, provided the slot is empty.
- R6: When `frame_mode` is 2'b00 (asynchronous), `crc_active` has no effect on `tx_empty`.
- R7: A `host_wr` while `tx_empty` is 0 is discarded: `slot_data` is unchanged and `overrun` is 1 in the next cycle.
- R8: Once set, `overrun` stays 1 until `rst` or `chan_rst`.
- R9: `tx_empty` is never 1 while `slot_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| chan_rst | input | 1 | Synchronous active-high channel reset, same effect as `rst` |
| frame_mode | input | 2 | Framing mode: 00 async, 01 char sync, 10 bit-oriented framed, 11 external sync |
| host_wr | input | 1 | Host write strobe, one character per cycle |
| host_data | input | DATA_W | Character written by the host |
| slot_advance | input | 1 | Next FIFO stage takes the slot's character this cycle |
| crc_active | input | 1 | Transmit engine is sending the CRC |
| tx_empty | output | 1 | Entry slot can take a character |
| overrun | output | 1 | Sticky: a write was dropped while `tx_empty` was 0 |
| slot_valid | output | 1 | Slot holds a character for the next stage |
| slot_data | output | DATA_W | Character held in the slot |

## Verification
The assertions check the following on every cycle:
- the reset outcome;
- the load and reject rules for host writes;
- the freeing of the slot;
- the CRC hold in synchronous modes;
- that asynchronous mode ignores the CRC indication;
- that the overrun bit stays set;
- that the flag and slot occupancy never disagree.

Some behaviour shows up only in the bench scenarios:
- that an advance into an empty slot leaves the whole state unchanged;
- that the flag recovers on the exact cycle after the CRC indication falls;
- that a channel reset clears an overrun set many cycles earlier;
- that random mixes of collisions (writes into a full or held slot, advances in the same cycle as writes, and mode changes while the CRC indication is high) keep every output in agreement with the bench's model.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

    typedef enum logic [1:0] {
        FRM_ASYNC   = 2'b00,
        FRM_CHSYNC  = 2'b01,
        FRM_BITFRM  = 2'b10,
        FRM_EXTSYNC = 2'b11
    } frame_mode_e;

    // Host write outcome for one cycle
    typedef struct packed {
        logic accept;
        logic reject;
    } wr_result_t;

    // Only the asynchronous mode sends no CRC, so every other mode may hold
    function automatic logic crc_may_hold(frame_mode_e m);
        return (m != FRM_ASYNC);
    endfunction

    function automatic wr_result_t judge_write(logic wr, logic flag);
        wr_result_t r;
        r.accept = wr & flag;
        r.reject = wr & ~flag;
        return r;
    endfunction

endpackage

// File: rtl/tbe_entry_slot.sv
module tbe_entry_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              advance,
    output logic              full_next,
    output logic              full_q,
    output logic [DATA_W-1:0] data_q
);

    always_comb begin
        if (load)
            full_next = 1'b1;
        else if (advance)
            full_next = 1'b0;
        else
            full_next = full_q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_next;
            if (load)
                data_q <= load_data;
        end
    end

endmodule

// File: rtl/tbe_flag_reg.sv
module tbe_flag_reg (
    input  logic clk,
    input  logic clr,
    input  logic full_next,
    input  logic hold,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (clr)
            flag_q <= 1'b1;
        else
            flag_q <= ~full_next & ~hold;
    end

endmodule

// File: rtl/tbe_overrun_latch.sv
module tbe_overrun_latch (
    input  logic clk,
    input  logic clr,
    input  logic set,
    output logic sticky_q
);

    always_ff @(posedge clk) begin
        if (clr)
            sticky_q <= 1'b0;
        else if (set)
            sticky_q <= 1'b1;
    end

endmodule

// File: rtl/tbe_status_tracker.sv
module tbe_status_tracker
    import tbe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  logic [1:0]        frame_mode,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              slot_advance,
    input  logic              crc_active,
    output logic              tx_empty,
    output logic              overrun,
    output logic              slot_valid,
    output logic [DATA_W-1:0] slot_data
);

    logic        clr;
    logic        hold;
    logic        full_next;
    wr_result_t  wres;
    frame_mode_e mode_e;

    assign clr    = rst | chan_rst;
    assign mode_e = frame_mode_e'(frame_mode);
    assign hold   = crc_active & crc_may_hold(mode_e);
    assign wres   = judge_write(host_wr, tx_empty);

    tbe_entry_slot #(.DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .clr       (clr),
        .load      (wres.accept),
        .load_data (host_data),
        .advance   (slot_advance),
        .full_next (full_next),
        .full_q    (slot_valid),
        .data_q    (slot_data)
    );

    tbe_flag_reg u_flag (
        .clk       (clk),
        .clr       (clr),
        .full_next (full_next),
        .hold      (hold),
        .flag_q    (tx_empty)
    );

    tbe_overrun_latch u_ovr (
        .clk      (clk),
        .clr      (clr),
        .set      (wres.reject),
        .sticky_q (overrun)
    );

endmodule

// File: rtl/tbe_status_checker.sv
module tbe_status_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              chan_rst,
    input logic [1:0]        frame_mode,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_data,
    input logic              slot_advance,
    input logic              crc_active,
    input logic              tx_empty,
    input logic              overrun,
    input logic              slot_valid,
    input logic [DATA_W-1:0] slot_data
);

    AST_CHAN_RESET: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (tx_empty && !overrun && !slot_valid && slot_data == '0)); // R1

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (host_wr && tx_empty) |=> (!tx_empty && slot_valid && slot_data == $past(host_data))); // R2

    AST_ADVANCE_FREES: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (slot_valid && slot_advance) |=> !slot_valid); // R3

    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (!slot_valid && slot_advance && !host_wr) |=> ($stable(slot_data) && !slot_valid)); // R4

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (frame_mode != 2'b00 && crc_active) |=> !tx_empty); // R5

    AST_ASYNC_NO_HOLD: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (frame_mode == 2'b00 && crc_active && tx_empty && !host_wr) |=> tx_empty); // R6

    AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (host_wr && !tx_empty) |=> (overrun && $stable(slot_data))); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst || chan_rst)
        overrun |=> overrun); // R8

    AST_FLAG_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        !(tx_empty && slot_valid)); // R9

endmodule

bind tbe_status_tracker tbe_status_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .chan_rst     (chan_rst),
    .frame_mode   (frame_mode),
    .host_wr      (host_wr),
    .host_data    (host_data),
    .slot_advance (slot_advance),
    .crc_active   (crc_active),
    .tx_empty     (tx_empty),
    .overrun      (overrun),
    .slot_valid   (slot_valid),
    .slot_data    (slot_data)
);

// File: tb/sim_tbe_status_tracker.sv
module sim_tbe_status_tracker;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst, chan_rst, host_wr, slot_advance, crc_active;
    logic [1:0]    frame_mode;
    logic [DW-1:0] host_data;
    logic          tx_empty, overrun, slot_valid;
    logic [DW-1:0] slot_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Bench model state
    logic          m_empty, m_ovr, m_full;
    logic [DW-1:0] m_data;

    always #2 clk = ~clk;

    tbe_status_tracker #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .frame_mode(frame_mode),
        .host_wr(host_wr), .host_data(host_data), .slot_advance(slot_advance),
        .crc_active(crc_active), .tx_empty(tx_empty), .overrun(overrun),
        .slot_valid(slot_valid), .slot_data(slot_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected next state from the requirements
    function automatic logic hold_of(logic [1:0] md, logic crc);
        return (md != 2'b00) && crc;
    endfunction

    task automatic model_step();
        if (rst || chan_rst) begin
            m_empty = 1'b1; m_ovr = 1'b0; m_full = 1'b0; m_data = '0;
        end else begin
            if (host_wr && !m_empty) m_ovr = 1'b1;
            if (host_wr && m_empty) begin
                m_full = 1'b1; m_data = host_data;
            end else if (slot_advance) begin
                m_full = 1'b0;
            end
            m_empty = !m_full && !hold_of(frame_mode, crc_active);
        end
    endtask

    task automatic cyc(input logic r, input logic cr, input logic [1:0] md,
                       input logic wr, input logic [DW-1:0] d,
                       input logic adv, input logic crc, input string tag);
        @(negedge clk);
        rst = r; chan_rst = cr; frame_mode = md; host_wr = wr;
        host_data = d; slot_advance = adv; crc_active = crc;
        @(posedge clk);
        model_step();
        #1;
        chk({tag, " tx_empty"},   int'(tx_empty),   int'(m_empty));
        chk({tag, " overrun"},    int'(overrun),    int'(m_ovr));
        chk({tag, " slot_valid"}, int'(slot_valid), int'(m_full));
        chk({tag, " slot_data"},  int'(slot_data),  int'(m_data));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_empty = 1'b1; m_ovr = 1'b0; m_full = 1'b0; m_data = '0;
        // R1: hardware reset
        cyc(1, 0, 2'b00, 0, 8'h00, 0, 0, "R1 hw reset");
        cyc(1, 0, 2'b00, 0, 8'h00, 0, 0, "R1 hw reset hold");
        // R2: accepted write
        cyc(0, 0, 2'b00, 1, 8'hA5, 0, 0, "R2 load");
        // R7 + R9: write while full discarded
        cyc(0, 0, 2'b00, 1, 8'h3C, 0, 0, "R7 drop");
        // R3 + R8: advance frees slot, overrun stays
        cyc(0, 0, 2'b00, 0, 8'h00, 1, 0, "R3 advance");
        cyc(0, 0, 2'b00, 0, 8'h00, 0, 0, "R8 sticky");
        // R4: advance into empty slot
        cyc(0, 0, 2'b00, 0, 8'hFF, 1, 0, "R4 idle advance");
        // R5: CRC hold in bit-oriented mode, write during hold dropped
        cyc(0, 0, 2'b10, 0, 8'h00, 0, 1, "R5 hold start");
        cyc(0, 0, 2'b10, 1, 8'h77, 0, 1, "R5 R7 write in hold");
        cyc(0, 0, 2'b10, 0, 8'h00, 0, 0, "R5 release");
        // R5 in char sync with full slot, then advance after CRC
        cyc(0, 0, 2'b01, 1, 8'h12, 0, 0, "R2 load sync");
        cyc(0, 0, 2'b01, 0, 8'h00, 1, 1, "R5 advance under hold");
        cyc(0, 0, 2'b01, 0, 8'h00, 0, 0, "R5 recover");
        // R6: async ignores CRC indication
        cyc(0, 0, 2'b00, 0, 8'h00, 0, 1, "R6 async crc");
        cyc(0, 0, 2'b00, 0, 8'h00, 0, 1, "R6 async crc hold");
        // R1: channel reset clears overrun and slot
        cyc(0, 0, 2'b00, 1, 8'h9A, 0, 0, "R2 load before creset");
        cyc(0, 1, 2'b11, 1, 8'h00, 0, 1, "R1 channel reset");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            cyc(1'b0, ($urandom_range(0, 199) == 0), md,
                ($urandom_range(0, 2) == 0), 8'($urandom),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0),
                "R2 R3 R5 R6 R7 R9 random");
        end
        finish_run();
    end

endmodule